// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

The block watches a single-bit serial stream. It takes one bit on every rising clock edge and raises a detect pulse each time the five most recent bits, oldest first, read 1, 0, 1, 1, 0. Matches may overlap. After a hit, the closing "10" of one occurrence counts as the opening of the next, so a repeating stream gives a pulse on every occurrence.

A five-state machine records the longest prefix of the pattern that the recent bits end in. After any mismatch it falls back to the longest shorter prefix that is still valid, and it does not restart from idle. Detect is a Mealy output. It goes high in the same cycle that the completing bit is presented, and the register update at the next edge moves the machine on. Reset is asynchronous and active low, and its release is assumed to be synchronised to the clock before it reaches the block.

Top module: `serial_pattern_detector`

## Requirements
- R1: While rst_n is low, detect is low and the machine is held idle. After release, no bit seen before or during reset counts toward a match.
- R2: detect is high in a cycle exactly when the bit on din in that cycle and the four bits before it, all taken since reset, read 1,0,1,1,0 with the oldest first. The pulse appears in the same cycle as the final 0, before the next rising edge.
- R3: detect never stays high for two cycles in a row.
- R4: Overlap is kept. The stream 1011010110 gives exactly two pulses, on bit 5 and on bit 10, and after each pulse the machine holds the "10" prefix.
- R5: In a run of ones, the newest 1 can still open a match. The stream 1111110110 gives exactly one pulse, on bit 10.
- R6: The prefix "100" keeps no partial credit. The stream 100110110 gives exactly one pulse, on bit 9.
- R7: The prefix "1010" keeps credit for "10". The stream 1010110 gives exactly one pulse, on bit 7.
- R8: The 3-bit state register holds only the five legal codes, 0 to 4, which stand for the matched prefix lengths 0 to 4. Any other code returns to idle on the next clock with detect low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data bit for the current cycle |
| detect | output | 1 | One-cycle pulse when din completes 1,0,1,1,0 |

## Verification
The assertions check four things on every cycle: that a pulse is backed by the actual five-bit history on din, that no pulse lasts longer than one cycle, that the machine lands back on the "10" prefix after every hit, and that the state code stays legal and detect stays quiet in reset. Whether every occurrence is found, and never an extra one, can only be shown by the bench scenarios. These are the overlap, run-of-ones and fallback streams, a reset in the middle of a partial match, and a long random stream, all compared bit by bit with a five-bit sliding-window model.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Number of bits in the watched sequence, and bits of state needed
  localparam int unsigned SEQ_LEN = 5;
  localparam int unsigned STATE_W = $clog2(SEQ_LEN);

  // Code = length of matched prefix of 1,0,1,1,0
  typedef enum logic [STATE_W-1:0] {
    ST_P0 = 3'd0,  // nothing matched
    ST_P1 = 3'd1,  // "1"
    ST_P2 = 3'd2,  // "10"
    ST_P3 = 3'd3,  // "101"
    ST_P4 = 3'd4   // "1011"
  } spd_state_e;
endpackage

// File: rtl/spd_next_state.sv
module spd_next_state
  import spd_pkg::*;
(
  input  spd_state_e cur_state,
  input  logic       bit_in,
  output spd_state_e nxt_state
);
  always_comb begin
    unique case (cur_state)
      ST_P0:   nxt_state = bit_in ? ST_P1 : ST_P0;
      ST_P1:   nxt_state = bit_in ? ST_P1 : ST_P2;  // newest 1 may start
      ST_P2:   nxt_state = bit_in ? ST_P3 : ST_P0;  // "100" keeps nothing
      ST_P3:   nxt_state = bit_in ? ST_P4 : ST_P2;  // "1010" keeps "10"
      ST_P4:   nxt_state = bit_in ? ST_P1 : ST_P2;  // hit keeps "10"
      default: nxt_state = ST_P0;                   // illegal code
    endcase
  end
endmodule

// File: rtl/spd_state_reg.sv
module spd_state_reg
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  spd_state_e state_d,
  output spd_state_e state_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_P0;
    else        state_q <= state_d;
  end

  // R8: only the five prefix codes ever appear in the register
  assert_state_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q <= ST_P4));
endmodule

// File: rtl/spd_detect_out.sv
module spd_detect_out
  import spd_pkg::*;
(
  input  spd_state_e cur_state,
  input  logic       bit_in,
  output logic       hit
);
  // Mealy: "1011" held and a 0 arriving completes the sequence
  always_comb hit = (cur_state == ST_P4) && !bit_in;
endmodule

// File: rtl/serial_pattern_detector.sv
module serial_pattern_detector
  import spd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic detect
);
  spd_state_e state_q;
  spd_state_e state_d;

  spd_next_state u_next (
    .cur_state (state_q),
    .bit_in    (din),
    .nxt_state (state_d)
  );

  spd_state_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .state_q (state_q)
  );

  spd_detect_out u_out (
    .cur_state (state_q),
    .bit_in    (din),
    .hit       (detect)
  );

  // R1: no pulse while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert_quiet_in_reset_R1: assert (!detect);
  end

  // R2: a pulse is backed by the real five-bit history on din
  assert_hit_history_R2: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> (!din && $past(din, 1) && $past(din, 2) && !$past(din, 3) && $past(din, 4)));

  // R3: pulses last one cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect);

  // R4: after a hit the machine keeps the "10" prefix for overlap
  assert_overlap_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> (state_q == ST_P2));
endmodule

// File: tb/serial_pattern_detector_tb_top.sv
module serial_pattern_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;
  localparam int RAND_BITS = 6000;

  logic clk;
  logic rst_n;
  logic din;
  logic detect;

  int total;
  int bad;
  bit finished;

  // sliding-window reference
  logic [3:0] hist;
  int nbits;
  int pulses;

  serial_pattern_detector dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .detect (detect)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic ref_hit(input logic [3:0] h, input int n, input logic b);
    return (n >= 4) && ({h, b} == 5'b10110);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: detect actual=%b expected=%b at bit %0d", tag, act, exp, nbits);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input string tag);
    @(negedge clk);
    din = b;
    #1;
    check(tag, detect, ref_hit(hist, nbits, b));
    if (detect === 1'b1) pulses++;
    hist = {hist[2:0], b};
    nbits++;
  endtask

  task automatic send_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1", tag);
  endtask

  // expects a pulse on exactly bit `pos` (1-based) of the stream, none elsewhere
  task automatic send_expect(input string s, input int pos_a, input int pos_b, input string tag);
    for (int i = 0; i < s.len(); i++) begin
      logic b;
      b = (s[i] == "1");
      @(negedge clk);
      din = b;
      #1;
      check(tag, detect, (i + 1 == pos_a) || (i + 1 == pos_b));
      hist = {hist[2:0], b};
      nbits++;
    end
  endtask

  task automatic do_reset(input string pre);
    @(negedge clk);
    rst_n = 1'b0;
    // R1: drive a completing pattern under reset, detect must stay low
    for (int i = 0; i < pre.len(); i++) begin
      @(negedge clk);
      din = (pre[i] == "1");
      #1;
      check("R1 quiet in reset", detect, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    din = 1'b0;
    hist = '0;
    nbits = 0;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    hist = '0; nbits = 0; pulses = 0;
    rst_n = 1'b0;
    din = 1'b0;
    #1;
    check("R1 reset state", detect, 1'b0);
    do_reset("10110110");

    // R1: prefix "1011" before reset must not combine with a 0 after it
    send_str("1011", "R1 pre-reset prefix");
    do_reset("1");
    send_bit(1'b0, "R1 no credit across reset");
    check("R1 no credit across reset", detect, 1'b0);

    // R4: overlapping occurrences
    do_reset("0");
    send_expect("1011010110", 5, 10, "R4 overlap");
    // R5: run of ones
    do_reset("0");
    send_expect("1111110110", 10, 0, "R5 run of ones");
    // R6: "100" loses credit
    do_reset("0");
    send_expect("100110110", 9, 0, "R6 fallback idle");
    // R7: "1010" keeps "10"
    do_reset("0");
    send_expect("1010110", 7, 0, "R7 fallback to 10");
    // R3: back-to-back repeats give isolated pulses
    do_reset("0");
    pulses = 0;
    send_str("101101101101101101", "R3 repeated");
    check_int("R3 pulse count on repeats", pulses, 5);

    // R2: long random stream, biased toward ones now and then
    do_reset("0");
    void'($urandom(32'd20240));
    pulses = 0;
    for (int i = 0; i < RAND_BITS; i++) begin
      logic b;
      if ((i / 500) % 2 == 0) b = logic'($urandom % 2);
      else                    b = logic'(($urandom % 4) != 0);
      send_bit(b, "R2 random stream");
    end
    total++;
    if (pulses == 0) begin
      bad++;
      $display("FAIL R2: random stream pulses actual=0 expected>0");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule